// File: doc/BRIEF.md
# I2C Controller Interrupt and FIFO Status Unit

This block gathers the event flags of an I2C master controller and turns them into one interrupt line. Events arrive from the bus engine as single-cycle pulses and are latched in sticky flags. Software clears each flag by reading a dedicated clear address, or clears all of them with one global clear read. Two further flags are levels: they follow the transmit and receive FIFO fill counts against programmable thresholds, and only hardware changes them. A mask selects which flags reach the interrupt output.

A pending transmit abort also drives a hold signal that keeps the transmit FIFO flushed until software reads the abort clear address. That read also empties the register that records the causes of the abort. The block also exposes a status word built from the FIFO full and empty flags and the activity inputs, and the two FIFO fill counts. Register access uses a read strobe and a write strobe with a byte address. Read data is combinational in the strobe cycle, and any clear caused by the read takes effect at the clock edge that ends that cycle.

Top module: `evt_status_unit`

## Requirements
- R1: An event pulse on `evt_pulse_i` sets the sticky flag at the same raw bit position. The positions are RX underflow 0, RX overflow 1, TX overflow 3, TX abort 6, activity 8, stop seen 9, start seen 10, general call 11. The raw word is read at address 0x04.
- R2: The mask (address 0x08, 12 bits) resets to 0x8FF. The masked word at address 0x00 equals raw AND mask. `irq_o` is high exactly when the masked word is nonzero.
- R3: Raw bit 4 (TX low) is high while the transmit level is at or below the effective TX threshold (address 0x0C). It drops when the level rises above the threshold.
- R4: Raw bit 2 (RX high) is high while the receive level is at or above the effective RX threshold (address 0x10). It drops when the level falls below the threshold.
- R5: Each FIFO holds 16 entries. A stored threshold above 16 acts as 16, and the stored value reads back unchanged.
- R6: Reading address 0x40 + 4*b clears sticky flag b at the end of the read cycle and leaves every other flag unchanged. Bit 0 of the read data shows the flag's value before the clear.
- R7: While the TX abort flag is set, `tx_flush_o` stays high. Each abort pulse ORs `abort_src_i` into the abort source register (address 0x20). Reading the abort clear address (0x58) drops `tx_flush_o` and zeroes the source register.
- R8: Reading the global clear address 0x24 clears every sticky flag and the abort source register. It leaves raw bits 2 and 4 as they were.
- R9: While `bus_active_i` is high, neither the activity clear (0x60) nor the global clear drops the activity flag.
- R10: If an event pulse and a clearing read hit the same flag in the same cycle, the flag ends set. For TX abort, the source register then holds only the new cause bits.
- R11: The status word at address 0x14 is: bit 0 bus active, bit 1 TX not full, bit 2 TX empty, bit 3 RX not empty, bit 4 RX full, bit 5 controller active. All other bits are zero.
- R12: Addresses 0x18 and 0x1C return the transmit and receive fill counts in bits 4:0, with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse_i | input | 12 | Event pulses, one per raw bit position |
| abort_src_i | input | 17 | Cause bits accompanying a TX abort pulse |
| bus_active_i | input | 1 | I2C bus currently busy |
| ctrl_active_i | input | 1 | Controller state machine not idle |
| tx_level_i | input | 5 | Transmit FIFO fill count |
| rx_level_i | input | 5 | Receive FIFO fill count |
| tx_full_i | input | 1 | Transmit FIFO full |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| rx_full_i | input | 1 | Receive FIFO full |
| rx_empty_i | input | 1 | Receive FIFO empty |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid in the strobe cycle |
| irq_o | output | 1 | Combined interrupt |
| tx_flush_o | output | 1 | Hold the transmit FIFO flushed |

## Verification
The assertions check, on every cycle, the relations between flags and time:
- a pulse always leaves its flag set, and a clear without a competing pulse drops it;
- the activity flag survives while the bus is busy;
- the flush hold persists until an abort clear is read;
- the source register is empty after a clear;
- the level flags at the FIFO's empty and full extremes.

Only the bench's sweeps can show the exact threshold boundaries, including the clamp above 16. They also show the address-to-bit mapping of every clear register, the isolation of one clear from its neighbours, and the full status word under all 64 input combinations.

// File: rtl/evt_pkg.sv
// Shared constants for the event/status unit: raw bit positions,
// the set of software-clearable bits and the register byte addresses.
package evt_pkg;
    localparam int RAW_W      = 12;
    localparam int B_RX_UNDER = 0;
    localparam int B_RX_OVER  = 1;
    localparam int B_RX_HIGH  = 2;
    localparam int B_TX_OVER  = 3;
    localparam int B_TX_LOW   = 4;
    localparam int B_TX_ABRT  = 6;
    localparam int B_ACTIVITY = 8;
    localparam int B_STOP     = 9;
    localparam int B_START    = 10;
    localparam int B_GEN_CALL = 11;

    // bits latched by events and cleared by software reads
    localparam logic [RAW_W-1:0] STICKY_MASK = 12'hF4B;
    localparam logic [RAW_W-1:0] MASK_RESET  = 12'h8FF;

    localparam logic [7:0] A_MSTAT   = 8'h00;
    localparam logic [7:0] A_RAW     = 8'h04;
    localparam logic [7:0] A_MASK    = 8'h08;
    localparam logic [7:0] A_TXTHR   = 8'h0C;
    localparam logic [7:0] A_RXTHR   = 8'h10;
    localparam logic [7:0] A_STATUS  = 8'h14;
    localparam logic [7:0] A_TXLVL   = 8'h18;
    localparam logic [7:0] A_RXLVL   = 8'h1C;
    localparam logic [7:0] A_SRC     = 8'h20;
    localparam logic [7:0] A_CLR_ALL = 8'h24;
    // per-bit clear address is CLR_BASE + 4*bit
    localparam logic [7:0] CLR_BASE  = 8'h40;
endpackage

// File: rtl/evt_level_cmp.sv
// Threshold comparator for one FIFO.
// Clamps the programmed threshold to DEPTH and compares it with the live
// fill level. AT_OR_BELOW=1 gives a "low" flag, 0 gives a "high" flag.
// Assumes level never exceeds DEPTH.
module evt_level_cmp #(
    parameter int DEPTH       = 16,
    parameter int THR_W       = 8,
    parameter bit AT_OR_BELOW = 1'b1,
    localparam int LVL_W      = $clog2(DEPTH) + 1
) (
    input  logic [LVL_W-1:0] level_i,
    input  logic [THR_W-1:0] thr_i,
    output logic             flag_o
);
    logic [LVL_W-1:0] eff_thr;

    // clamp the threshold to the FIFO depth
    always_comb begin
        if (thr_i > THR_W'(DEPTH)) eff_thr = LVL_W'(DEPTH);
        else                       eff_thr = thr_i[LVL_W-1:0];
    end

    generate
        if (AT_OR_BELOW) begin : g_low
            assign flag_o = (level_i <= eff_thr);
        end else begin : g_high
            assign flag_o = (level_i >= eff_thr);
        end
    endgenerate
endmodule

// File: rtl/evt_sticky_bank.sv
// Bank of read-to-clear event flags and the abort-source accumulator.
// Each bit in SMASK is set by an event pulse and cleared by its own clear
// strobe or the global clear. A set beats a clear in the same cycle. The
// activity bit ignores clears while the bus is busy. Other bits read as 0.
module evt_sticky_bank #(
    parameter int              RAW_W    = 12,
    parameter logic [RAW_W-1:0] SMASK   = 12'hF4B,
    parameter int              ACT_BIT  = 8,
    parameter int              ABRT_BIT = 6,
    parameter int              SRC_W    = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RAW_W-1:0] set_i,
    input  logic [RAW_W-1:0] clr_i,
    input  logic             clr_all_i,
    input  logic             bus_active_i,
    input  logic [SRC_W-1:0] src_i,
    output logic [RAW_W-1:0] flags_o,
    output logic [SRC_W-1:0] src_o
);
    logic unused_nonsticky;
    assign unused_nonsticky = ^((set_i | clr_i) & ~SMASK);

    generate
        for (genvar i = 0; i < RAW_W; i++) begin : g_bit
            if (SMASK[i]) begin : g_flag
                localparam bit IS_ACT = (i == ACT_BIT);
                logic q;
                logic clr_hit;
                assign clr_hit = (clr_i[i] | clr_all_i) & ~(IS_ACT & bus_active_i);

                // latch the event, drop it on an accepted clear
                always_ff @(posedge clk) begin
                    if (!rst_n)        q <= 1'b0;
                    else if (set_i[i]) q <= 1'b1;
                    else if (clr_hit)  q <= 1'b0;
                end
                assign flags_o[i] = q;

                AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                    set_i[i] |=> flags_o[i]); // R10
                AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
                    ((clr_i[i] || clr_all_i) && !set_i[i] && !(IS_ACT && bus_active_i))
                    |=> !flags_o[i]); // R6
            end else begin : g_none
                assign flags_o[i] = 1'b0;
            end
        end
    endgenerate

    logic src_clr;
    logic [SRC_W-1:0] src_q;
    assign src_clr = clr_i[ABRT_BIT] | clr_all_i;

    // accumulate abort causes, a new abort replaces cleared history
    always_ff @(posedge clk) begin
        if (!rst_n)                src_q <= '0;
        else if (set_i[ABRT_BIT])  src_q <= src_clr ? src_i : (src_q | src_i);
        else if (src_clr)          src_q <= '0;
    end
    assign src_o = src_q;

    AST_ACT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_active_i && flags_o[ACT_BIT]) |=> flags_o[ACT_BIT]); // R9
    AST_SRC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (src_clr && !set_i[ABRT_BIT]) |=> (src_o == '0)); // R7
endmodule

// File: rtl/evt_regs.sv
// Register front end: holds mask and thresholds, decodes read-to-clear
// addresses into strobes, and muxes read data combinationally.
// Assumes a read strobe lasts one cycle per intended clear.
module evt_regs
    import evt_pkg::*;
#(
    parameter int THR_W  = 8,
    parameter int SRC_W  = 17,
    parameter int LVL_W  = 5,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [RAW_W-1:0]  raw_i,
    input  logic [SRC_W-1:0]  src_i,
    input  logic [5:0]        status_i,
    input  logic [LVL_W-1:0]  tx_level_i,
    input  logic [LVL_W-1:0]  rx_level_i,
    output logic [RAW_W-1:0]  mask_o,
    output logic [THR_W-1:0]  tx_thr_o,
    output logic [THR_W-1:0]  rx_thr_o,
    output logic [RAW_W-1:0]  clr_o,
    output logic              clr_all_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int SLOTS = 16;

    logic [RAW_W-1:0] mask_q;
    logic [THR_W-1:0] tx_thr_q, rx_thr_q;
    logic [SLOTS-1:0] raw_pad;
    logic unused_wdata;

    assign raw_pad      = SLOTS'(raw_i);
    assign unused_wdata = ^wdata_i[DATA_W-1:RAW_W];

    // programmable mask and thresholds
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= MASK_RESET;
            tx_thr_q <= '0;
            rx_thr_q <= '0;
        end else if (wr_i) begin
            if (addr_i == ADDR_W'(A_MASK))  mask_q   <= wdata_i[RAW_W-1:0];
            if (addr_i == ADDR_W'(A_TXTHR)) tx_thr_q <= wdata_i[THR_W-1:0];
            if (addr_i == ADDR_W'(A_RXTHR)) rx_thr_q <= wdata_i[THR_W-1:0];
        end
    end
    assign mask_o   = mask_q;
    assign tx_thr_o = tx_thr_q;
    assign rx_thr_o = rx_thr_q;

    // per-bit clear strobes
    generate
        for (genvar b = 0; b < RAW_W; b++) begin : g_clr
            assign clr_o[b] = rd_i && (addr_i == ADDR_W'(int'(CLR_BASE) + 4 * b));
        end
    endgenerate
    assign clr_all_o = rd_i && (addr_i == ADDR_W'(A_CLR_ALL));

    // read data mux
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_W'(A_MSTAT):   rdata_o = DATA_W'(raw_i & mask_q);
            ADDR_W'(A_RAW):     rdata_o = DATA_W'(raw_i);
            ADDR_W'(A_MASK):    rdata_o = DATA_W'(mask_q);
            ADDR_W'(A_TXTHR):   rdata_o = DATA_W'(tx_thr_q);
            ADDR_W'(A_RXTHR):   rdata_o = DATA_W'(rx_thr_q);
            ADDR_W'(A_STATUS):  rdata_o = DATA_W'(status_i);
            ADDR_W'(A_TXLVL):   rdata_o = DATA_W'(tx_level_i);
            ADDR_W'(A_RXLVL):   rdata_o = DATA_W'(rx_level_i);
            ADDR_W'(A_SRC):     rdata_o = DATA_W'(src_i);
            ADDR_W'(A_CLR_ALL): rdata_o = DATA_W'(|(raw_i & STICKY_MASK));
            default: begin
                if (addr_i[7:6] == 2'b01 && addr_i[1:0] == 2'b00)
                    rdata_o = DATA_W'(raw_pad[addr_i[5:2]]);
            end
        endcase
    end

    AST_MASK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && addr_i == ADDR_W'(A_MASK)) |=> $stable(mask_o)); // R2
endmodule

// File: rtl/evt_status_unit.sv
// Top of the interrupt and FIFO status unit.
// Combines sticky event flags with FIFO threshold flags into the raw word,
// masks it into the interrupt, and drives the TX flush hold from the abort
// flag. Assumes event pulses are one cycle and FIFO levels never exceed DEPTH.
module evt_status_unit
    import evt_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int THR_W  = 8,
    parameter int SRC_W  = 17,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    localparam int LVL_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RAW_W-1:0]  evt_pulse_i,
    input  logic [SRC_W-1:0]  abort_src_i,
    input  logic              bus_active_i,
    input  logic              ctrl_active_i,
    input  logic [LVL_W-1:0]  tx_level_i,
    input  logic [LVL_W-1:0]  rx_level_i,
    input  logic              tx_full_i,
    input  logic              tx_empty_i,
    input  logic              rx_full_i,
    input  logic              rx_empty_i,
    input  logic              reg_rd_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o,
    output logic              tx_flush_o
);
    localparam logic [ADDR_W-1:0] ABRT_CLR = ADDR_W'(int'(CLR_BASE) + 4 * B_TX_ABRT);

    logic [RAW_W-1:0] sticky, raw, mask, clr_vec;
    logic [THR_W-1:0] tx_thr, rx_thr;
    logic [SRC_W-1:0] src;
    logic             clr_all, tx_low, rx_high;
    logic [5:0]       status;

    evt_level_cmp #(.DEPTH(DEPTH), .THR_W(THR_W), .AT_OR_BELOW(1'b1)) u_txcmp (
        .level_i(tx_level_i), .thr_i(tx_thr), .flag_o(tx_low));
    evt_level_cmp #(.DEPTH(DEPTH), .THR_W(THR_W), .AT_OR_BELOW(1'b0)) u_rxcmp (
        .level_i(rx_level_i), .thr_i(rx_thr), .flag_o(rx_high));

    evt_sticky_bank #(.RAW_W(RAW_W), .SMASK(STICKY_MASK), .ACT_BIT(B_ACTIVITY),
                      .ABRT_BIT(B_TX_ABRT), .SRC_W(SRC_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .set_i(evt_pulse_i), .clr_i(clr_vec),
        .clr_all_i(clr_all), .bus_active_i(bus_active_i), .src_i(abort_src_i),
        .flags_o(sticky), .src_o(src));

    // merge level flags into the raw word
    always_comb begin
        raw            = sticky;
        raw[B_TX_LOW]  = tx_low;
        raw[B_RX_HIGH] = rx_high;
    end

    assign status = {ctrl_active_i, rx_full_i, ~rx_empty_i, tx_empty_i, ~tx_full_i, bus_active_i};

    evt_regs #(.THR_W(THR_W), .SRC_W(SRC_W), .LVL_W(LVL_W), .ADDR_W(ADDR_W),
               .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .rd_i(reg_rd_i), .wr_i(reg_wr_i),
        .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .raw_i(raw), .src_i(src),
        .status_i(status), .tx_level_i(tx_level_i), .rx_level_i(rx_level_i),
        .mask_o(mask), .tx_thr_o(tx_thr), .rx_thr_o(rx_thr), .clr_o(clr_vec),
        .clr_all_o(clr_all), .rdata_o(reg_rdata_o));

    assign irq_o      = |(raw & mask);
    assign tx_flush_o = sticky[B_TX_ABRT];

    AST_FLUSH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_flush_o && !(reg_rd_i && (reg_addr_i == ABRT_CLR ||
                                      reg_addr_i == ADDR_W'(A_CLR_ALL))))
        |=> tx_flush_o); // R7
    AST_TXLOW_AT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level_i == '0) |-> raw[B_TX_LOW]); // R3
    AST_RXHIGH_AT_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level_i == LVL_W'(DEPTH)) |-> raw[B_RX_HIGH]); // R4
endmodule

// File: tb/sim_evt_status_unit.sv
module sim_evt_status_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] evt = '0;
    logic [16:0] asrc = '0;
    logic        bact = 0, cact = 0, txf = 0, txe = 0, rxf = 0, rxe = 0;
    logic [4:0]  txl = '0, rxl = '0;
    logic        rd = 0, wr = 0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic        irq, flush;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [31:0] d;

    localparam logic [11:0] STK = 12'hF4B;

    always #10 clk = ~clk;

    evt_status_unit u0 (
        .clk(clk), .rst_n(rst_n), .evt_pulse_i(evt), .abort_src_i(asrc),
        .bus_active_i(bact), .ctrl_active_i(cact), .tx_level_i(txl),
        .rx_level_i(rxl), .tx_full_i(txf), .tx_empty_i(txe), .rx_full_i(rxf),
        .rx_empty_i(rxe), .reg_rd_i(rd), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .tx_flush_o(flush));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic rdreg(input logic [7:0] a, output logic [31:0] v);
        addr = a; rd = 1; #2 v = rdata;
        @(negedge clk); rd = 0;
    endtask

    task automatic wrreg(input logic [7:0] a, input logic [31:0] v);
        addr = a; wdata = v; wr = 1;
        @(negedge clk); wr = 0;
    endtask

    task automatic pulse(input logic [11:0] e, input logic [16:0] s);
        evt = e; asrc = s;
        @(negedge clk); evt = '0; asrc = '0;
    endtask

    function automatic logic [7:0] clra(input int b);
        return 8'(8'h40 + 4 * b);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // reset state: thresholds 0, levels 0 -> both level bits high
        rdreg(8'h08, d); chk("R2 mask reset", d, 32'h8FF);
        rdreg(8'h04, d); chk("R1 raw reset", d, 32'h014);
        rdreg(8'h20, d); chk("R7 source reset", d, 32'h0);
        chk("R2 irq reset", {31'b0, irq}, 32'h1);
        chk("R7 flush reset", {31'b0, flush}, 32'h0);

        // R3 R4 R5 threshold and level sweep
        for (int t = 0; t <= 20; t++) begin
            wrreg(8'h0C, t); wrreg(8'h10, t);
            rdreg(8'h0C, d); chk("R5 tx threshold readback", d, t);
            rdreg(8'h10, d); chk("R5 rx threshold readback", d, t);
            for (int l = 0; l <= 16; l++) begin
                int eff;
                eff = (t > 16) ? 16 : t;
                txl = 5'(l); rxl = 5'(l);
                rdreg(8'h04, d);
                chk("R3 tx low flag", {31'b0, d[4]}, {31'b0, (l <= eff)});
                chk("R4 rx high flag", {31'b0, d[2]}, {31'b0, (l >= eff)});
            end
        end

        // quiet level flags: levels 5, tx thr 0, rx thr 16
        txl = 5; rxl = 5;
        wrreg(8'h0C, 0); wrreg(8'h10, 16);

        // R1 R6: set each sticky bit, clear it alone
        for (int b = 0; b < 12; b++) begin
            if (STK[b]) begin
                logic [11:0] one;
                one = 12'(1) << b;
                pulse(STK, 17'h0);
                rdreg(8'h04, d); chk("R1 all sticky set", d, {20'b0, STK});
                rdreg(clra(b), d); chk("R6 clear read shows flag", d, 32'h1);
                rdreg(8'h04, d); chk("R6 only own bit cleared", d, {20'b0, STK & ~one});
                rdreg(8'h24, d);
                pulse(one, 17'h0);
                rdreg(8'h04, d); chk("R1 single event position", d, {20'b0, one});
                rdreg(8'h24, d);
            end
        end

        // R2 mask sweep with all sticky flags set
        pulse(STK, 17'h0);
        for (int m = -1; m < 12; m++) begin
            logic [11:0] mk;
            mk = (m < 0) ? 12'h000 : (12'(1) << m);
            if (m == 11) mk = 12'hFFF;
            wrreg(8'h08, {20'b0, mk});
            rdreg(8'h00, d); chk("R2 masked word", d, {20'b0, STK & mk});
            chk("R2 irq", {31'b0, irq}, {31'b0, |(STK & mk)});
        end
        wrreg(8'h08, 32'h8FF);
        rdreg(8'h24, d);

        // R7 abort holds flush, source accumulates, abort clear releases
        pulse(12'h040, 17'h01234);
        pulse(12'h040, 17'h10010);
        chk("R7 flush set", {31'b0, flush}, 32'h1);
        rdreg(8'h20, d); chk("R7 source accumulates", d, 32'h11234);
        rdreg(clra(0), d); rdreg(clra(8), d);
        chk("R7 flush held by other clears", {31'b0, flush}, 32'h1);
        rdreg(8'h58, d); chk("R7 abort clear reads flag", d, 32'h1);
        chk("R7 flush released", {31'b0, flush}, 32'h0);
        rdreg(8'h20, d); chk("R7 source zeroed", d, 32'h0);

        // R8 global clear keeps level flags
        wrreg(8'h0C, 16); wrreg(8'h10, 0);
        pulse(STK, 17'h00FFF);
        rdreg(8'h24, d); chk("R8 global clear read", d, 32'h1);
        rdreg(8'h04, d); chk("R8 only level bits remain", d, 32'h014);
        rdreg(8'h20, d); chk("R8 source zeroed", d, 32'h0);
        chk("R8 flush dropped", {31'b0, flush}, 32'h0);
        wrreg(8'h0C, 0); wrreg(8'h10, 16);

        // R9 activity clear blocked while bus busy
        pulse(12'h100, 17'h0);
        bact = 1;
        rdreg(clra(8), d);
        rdreg(8'h04, d); chk("R9 activity kept on own clear", d, 32'h100);
        rdreg(8'h24, d);
        rdreg(8'h04, d); chk("R9 activity kept on global clear", d, 32'h100);
        bact = 0;
        rdreg(clra(8), d);
        rdreg(8'h04, d); chk("R9 activity cleared when idle", d, 32'h0);

        // R10 set wins over a same-cycle clear
        for (int b = 0; b < 12; b++) begin
            if (STK[b]) begin
                evt = 12'(1) << b; asrc = 17'h4;
                rdreg(clra(b), d);
                evt = '0; asrc = '0;
                rdreg(8'h04, d); chk("R10 set beats clear", d, 32'(12'(1) << b));
                if (b == 6) begin
                    rdreg(8'h20, d); chk("R10 source holds new cause", d, 32'h4);
                end
                rdreg(8'h24, d);
            end
        end
        pulse(12'h040, 17'h00100);
        evt = 12'h040; asrc = 17'h00002;
        rdreg(8'h24, d);
        evt = '0; asrc = '0;
        rdreg(8'h20, d); chk("R10 source replaced on global clear", d, 32'h2);
        rdreg(8'h24, d);

        // R11 status word, all input combinations
        for (int s = 0; s < 64; s++) begin
            logic [5:0] v;
            v = 6'(s);
            bact = v[0]; txf = v[1]; txe = v[2]; rxe = v[3]; rxf = v[4]; cact = v[5];
            rdreg(8'h14, d);
            chk("R11 status word", d,
                {26'b0, v[5], v[4], ~v[3], v[2], ~v[1], v[0]});
        end
        bact = 0;

        // R12 fill counts
        for (int l = 0; l <= 16; l++) begin
            txl = 5'(l); rxl = 5'(16 - l);
            rdreg(8'h18, d); chk("R12 tx level", d, l);
            rdreg(8'h1C, d); chk("R12 rx level", d, 16 - l);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule